// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block holds the inter-processor interrupt (IPI) state for a small cluster of CPUs. Each CPU owns two IPI kinds: "other", which any CPU raises by writing a destination bitmap, and "self", which is raised through a per-CPU window. Every IPI kind has one pending bit and one mask bit per CPU. A CPU services its IPIs by reading its event register. That read reports the highest-priority deliverable source and masks the reported IPI in the same access. Software then acknowledges the IPI to clear it and unmasks it again when ready.

All accesses arrive on a single register port that also carries the index of the accessing CPU. Local addresses act on the accessing CPU. A strided window lets any CPU raise, clear, mask or unmask the IPIs of a chosen CPU. Hardware-line events are owned elsewhere. Each CPU's hardware-line event arrives here as a valid flag and a number, and it is placed ahead of the IPIs in the event word. Per-CPU interrupt request outputs show whether an unmasked IPI is pending.

Top module: `ipi_unit`

## Requirements
- R1: After reset, both IPI kinds are masked and not pending on every CPU, `ipi_irq` is all zero and `bus_rdata` is zero.
- R2: A write to the send address 0x0008 with bit c set makes the "other" IPI pending at CPU c, for every set bit at once; clear bits have no effect.
- R3: The event word carries its type in bits 31:16 and its number in bits 15:0. An IPI is reported as type 4 with number 1 for "other" and 2 for "self". The word is zero when nothing is deliverable.
- R4: A write to the acknowledge address 0x000C clears, for the accessing CPU only, the "other" pending bit when bit 0 is set and the "self" pending bit when bit 31 is set.
- R5: Writes to mask-set 0x0024 and mask-clear 0x0028 are write-one. Bit 0 selects "other" and bit 31 selects "self", and zero bits change nothing. Reading either address returns the accessing CPU's mask as {self in bit 31, other in bit 0}.
- R6: Reading the event address 0x0004 sets the mask bit of the IPI it reports. The pending bit stays set until it is acknowledged.
- R7: The window for CPU w starts at 0x1000 + 128*w. Offsets 0x08 (set pending), 0x0C (clear pending), 0x24 (mask-set) and 0x28 (mask-clear) use the bit-0/bit-31 encoding and act on CPU w, whichever CPU makes the access.
- R8: When `hw_evt_valid` is high for the reading CPU, the event word is type 1 with that CPU's `hw_evt_num`, and no IPI mask changes.
- R9: Sending an IPI that is already pending leaves a single occurrence, so one acknowledge clears it.
- R10: A masked pending IPI stays pending and is reported once unmasked. `ipi_irq[c]` is high exactly when CPU c has an unmasked pending IPI.
- R11: When both kinds are deliverable, "other" is reported before "self".
- R12: Read data appears on `bus_rdata` in the cycle after the read and holds until the next read. Reading 0x000C returns the accessing CPU's pending bits as {self in bit 31, other in bit 0}. Other addresses read as zero, and an access with both write and read high is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_cpu | input | CPU_W | Index of the accessing CPU |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_evt_valid | input | NCPU | Hardware-line event waiting, one bit per CPU |
| hw_evt_num | input | 16*NCPU | Hardware-line event number, 16 bits per CPU |
| ipi_irq | output | NCPU | Unmasked IPI pending, one bit per CPU |

## Verification
A corrupted pending or mask bit shows on `ipi_irq` on the next clock edge, because the request output comes straight from that state. A wrong event word or a missed auto-mask shows in `bus_rdata` one cycle after an event read, and again on the following event read, which would repeat or skip a source. The bench therefore compares both outputs against a behavioural model on every clock. Directed sequences drive the mask and acknowledge paths, and a random phase stirs every address.

// File: rtl/ipi_pkg.sv
// Shared definitions for the IPI unit: address map, bit positions, event
// encoding and the decoded operation type.
package ipi_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    // Local ("this CPU") view
    localparam logic [ADDR_W-1:0] A_EVENT = 16'h0004;
    localparam logic [ADDR_W-1:0] A_SEND  = 16'h0008;
    localparam logic [ADDR_W-1:0] A_ACK   = 16'h000C;
    localparam logic [ADDR_W-1:0] A_MSET  = 16'h0024;
    localparam logic [ADDR_W-1:0] A_MCLR  = 16'h0028;

    // Explicit per-CPU window
    localparam logic [ADDR_W-1:0] WIN_BASE   = 16'h1000;
    localparam int                WIN_STRIDE = 128;
    localparam logic [6:0] W_SET  = 7'h08;
    localparam logic [6:0] W_CLR  = 7'h0C;
    localparam logic [6:0] W_MSET = 7'h24;
    localparam logic [6:0] W_MCLR = 7'h28;

    // Bit positions of the two kinds in ack/mask/window words
    localparam int BIT_OTHER = 0;
    localparam int BIT_SELF  = 31;

    // Event word fields
    localparam logic [15:0] EVT_HW    = 16'd1;
    localparam logic [15:0] EVT_IPI   = 16'd4;
    localparam logic [15:0] NUM_OTHER = 16'd1;
    localparam logic [15:0] NUM_SELF  = 16'd2;

    typedef enum logic [3:0] {
        OP_IDLE, OP_SEND, OP_ACK, OP_MSET, OP_MCLR,
        OP_EVT, OP_RDPEND, OP_RDMASK,
        OP_WSET, OP_WCLR, OP_WMSET, OP_WMCLR
    } ipi_op_e;
endpackage

// File: rtl/ipi_addr_dec.sv
// Address decoder: turns one register access into an operation and the
// CPU it targets. Assumes at most one access per cycle; write wins over read.
module ipi_addr_dec
    import ipi_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [CPU_W-1:0]  cpu,
    input  logic [ADDR_W-1:0] addr,
    output ipi_op_e           op,
    output logic [CPU_W-1:0]  tgt
);
    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(NCPU * WIN_STRIDE);

    logic [ADDR_W-1:0] rel;
    logic              in_win;

    // Locate the access inside the per-CPU window region
    always_comb begin
        rel    = addr - WIN_BASE;
        in_win = (addr >= WIN_BASE) && (rel < WIN_SPAN);
    end

    // Pick the operation and its target CPU
    always_comb begin
        op  = OP_IDLE;
        tgt = cpu;
        if (wr) begin
            if (in_win) begin
                tgt = rel[7 +: CPU_W];
                case (rel[6:0])
                    W_SET:   op = OP_WSET;
                    W_CLR:   op = OP_WCLR;
                    W_MSET:  op = OP_WMSET;
                    W_MCLR:  op = OP_WMCLR;
                    default: op = OP_IDLE;
                endcase
            end else begin
                case (addr)
                    A_SEND:  op = OP_SEND;
                    A_ACK:   op = OP_ACK;
                    A_MSET:  op = OP_MSET;
                    A_MCLR:  op = OP_MCLR;
                    default: op = OP_IDLE;
                endcase
            end
        end else if (rd) begin
            case (addr)
                A_EVENT:        op = OP_EVT;
                A_ACK:          op = OP_RDPEND;
                A_MSET, A_MCLR: op = OP_RDMASK;
                default:        op = OP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ipi_slot.sv
// State of one CPU: a pending and a mask bit for each IPI kind
// (index 0 = other, 1 = self). Assumes set and clear never coincide,
// which one access per cycle guarantees.
module ipi_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set,
    input  logic [1:0] clr,
    input  logic [1:0] mset,
    input  logic [1:0] mclr,
    input  logic [1:0] amask,
    output logic [1:0] pend,
    output logic [1:0] mask,
    output logic       req
);
    // Pending and mask update; a repeated set is absorbed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 2'b00;
            mask <= 2'b11;
        end else begin
            pend <= (pend | set) & ~clr;
            mask <= (mask | mset | amask) & ~mclr;
        end
    end

    // Request whenever some kind is both pending and unmasked
    always_comb req = |(pend & ~mask);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask == 2'b11 && pend == 2'b00));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[0] && !set[0]) |=> !pend[0]);
    a_r6_automask: assert property (@(posedge clk) disable iff (!rst_n)
        (amask[1] && !mclr[1]) |=> mask[1]);
    a_r10_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !clr[0]) |=> pend[0]);
    a_r10_hold_self: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && !clr[1]) |=> pend[1]);
endmodule

// File: rtl/ipi_evt_enc.sv
// Event encoder for one CPU: hardware-line event first, then "other",
// then "self". Reports which IPI would be auto-masked by the read.
module ipi_evt_enc
    import ipi_pkg::*;
(
    input  logic              hw_valid,
    input  logic [15:0]       hw_num,
    input  logic [1:0]        pend,
    input  logic [1:0]        mask,
    output logic [DATA_W-1:0] word,
    output logic [1:0]        amask
);
    logic [1:0] live;

    // Priority selection of the reported source
    always_comb begin
        live  = pend & ~mask;
        word  = '0;
        amask = 2'b00;
        if (hw_valid) begin
            word = {EVT_HW, hw_num};
        end else if (live[0]) begin
            word  = {EVT_IPI, NUM_OTHER};
            amask = 2'b01;
        end else if (live[1]) begin
            word  = {EVT_IPI, NUM_SELF};
            amask = 2'b10;
        end
    end

    // Guards on the selection
    always_comb begin
        a_r3_one_report: assert ($onehot0(amask));
        if (hw_valid) a_r8_hw_first: assert (amask == 2'b00);
        if (amask[1]) a_r11_other_first: assert (!(pend[0] && !mask[0]));
    end
endmodule

// File: rtl/ipi_unit.sv
// Top of the IPI unit: decodes the register port, fans controls out to
// one state slot per CPU and returns registered read data.
// Assumes one register access per cycle on a single shared port.
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [CPU_W-1:0]    bus_cpu,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NCPU-1:0]     hw_evt_valid,
    input  logic [16*NCPU-1:0]  hw_evt_num,
    output logic [NCPU-1:0]     ipi_irq
);
    ipi_op_e            op;
    logic [CPU_W-1:0]   tgt;
    logic [1:0]         pend_a [NCPU];
    logic [1:0]         mask_a [NCPU];
    logic [1:0]         sel_pend, sel_mask, enc_amask;
    logic [DATA_W-1:0]  enc_word;
    logic [1:0]         wbits;

    ipi_addr_dec #(.NCPU(NCPU), .CPU_W(CPU_W)) u_dec (
        .wr(bus_wr), .rd(bus_rd), .cpu(bus_cpu), .addr(bus_addr),
        .op(op), .tgt(tgt)
    );

    // Kind-select bits of a write word
    always_comb wbits = {bus_wdata[BIT_SELF], bus_wdata[BIT_OTHER]};

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic       hit;
        logic [1:0] set, clr, mset, mclr, amask;

        // Per-CPU controls derived from the decoded access
        always_comb begin
            hit     = (tgt == CPU_W'(c));
            set[0]  = (op == OP_SEND && bus_wdata[c]) ||
                      (op == OP_WSET && hit && wbits[0]);
            set[1]  = op == OP_WSET && hit && wbits[1];
            clr     = ((op == OP_ACK  || op == OP_WCLR)  && hit) ? wbits : 2'b00;
            mset    = ((op == OP_MSET || op == OP_WMSET) && hit) ? wbits : 2'b00;
            mclr    = ((op == OP_MCLR || op == OP_WMCLR) && hit) ? wbits : 2'b00;
            amask   = (op == OP_EVT && hit) ? enc_amask : 2'b00;
        end

        ipi_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .set(set), .clr(clr), .mset(mset), .mclr(mclr), .amask(amask),
            .pend(pend_a[c]), .mask(mask_a[c]), .req(ipi_irq[c])
        );

        a_r2_send_pends: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_SEND && bus_wdata[c]) |=> pend_a[c][0]);
    end

    // State of the CPU the current access targets
    always_comb begin
        sel_pend = pend_a[tgt];
        sel_mask = mask_a[tgt];
    end

    ipi_evt_enc u_enc (
        .hw_valid(hw_evt_valid[tgt]), .hw_num(hw_evt_num[16*tgt +: 16]),
        .pend(sel_pend), .mask(sel_mask),
        .word(enc_word), .amask(enc_amask)
    );

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd && !bus_wr) begin
            case (op)
                OP_EVT:    bus_rdata <= enc_word;
                OP_RDPEND: bus_rdata <= {sel_pend[1], 30'd0, sel_pend[0]};
                OP_RDMASK: bus_rdata <= {sel_mask[1], 30'd0, sel_mask[0]};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/test_ipi_unit.sv
module test_ipi_unit;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0]    hw_evt_valid = '0;
    logic [16*NC-1:0] hw_evt_num = '0;
    logic [NC-1:0]    ipi_irq;

    always #5 clk = ~clk;

    ipi_unit #(.NCPU(NC)) i_ipi_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hw_evt_valid(hw_evt_valid),
        .hw_evt_num(hw_evt_num), .ipi_irq(ipi_irq)
    );

    int    total = 0, bad = 0;
    bit    done = 0, armed = 0;
    string cur_tag = "R1", exp_tag = "R1";
    bit    m_pend [NC][2];
    bit    m_mask [NC][2];
    logic [31:0] exp_rd = '0;

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        int w, off;
        exp_tag = cur_tag;
        armed   = 1;
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_pend[c][0] = 0; m_pend[c][1] = 0;
                m_mask[c][0] = 1; m_mask[c][1] = 1;
            end
            exp_rd = 0;
        end else if (bus_wr) begin
            w = -1; off = 0;
            if (bus_addr >= 16'h1000 && bus_addr < 16'h1000 + NC*128) begin
                w   = (int'(bus_addr) - 'h1000) / 128;
                off = (int'(bus_addr) - 'h1000) % 128;
            end
            if (bus_addr == 16'h0008)
                for (int c = 0; c < NC; c++) if (bus_wdata[c]) m_pend[c][0] = 1;
            if (bus_addr == 16'h000C) begin
                if (bus_wdata[0])  m_pend[bus_cpu][0] = 0;
                if (bus_wdata[31]) m_pend[bus_cpu][1] = 0;
            end
            if (bus_addr == 16'h0024) begin
                if (bus_wdata[0])  m_mask[bus_cpu][0] = 1;
                if (bus_wdata[31]) m_mask[bus_cpu][1] = 1;
            end
            if (bus_addr == 16'h0028) begin
                if (bus_wdata[0])  m_mask[bus_cpu][0] = 0;
                if (bus_wdata[31]) m_mask[bus_cpu][1] = 0;
            end
            if (w >= 0) begin
                if (off == 'h08) begin
                    if (bus_wdata[0]) m_pend[w][0] = 1;
                    if (bus_wdata[31]) m_pend[w][1] = 1;
                end
                if (off == 'h0C) begin
                    if (bus_wdata[0]) m_pend[w][0] = 0;
                    if (bus_wdata[31]) m_pend[w][1] = 0;
                end
                if (off == 'h24) begin
                    if (bus_wdata[0]) m_mask[w][0] = 1;
                    if (bus_wdata[31]) m_mask[w][1] = 1;
                end
                if (off == 'h28) begin
                    if (bus_wdata[0]) m_mask[w][0] = 0;
                    if (bus_wdata[31]) m_mask[w][1] = 0;
                end
            end
        end else if (bus_rd) begin
            exp_rd = 0;
            if (bus_addr == 16'h0004) begin
                if (hw_evt_valid[bus_cpu])
                    exp_rd = {16'd1, hw_evt_num[16*bus_cpu +: 16]};
                else if (m_pend[bus_cpu][0] && !m_mask[bus_cpu][0]) begin
                    exp_rd = 32'h0004_0001; m_mask[bus_cpu][0] = 1;
                end else if (m_pend[bus_cpu][1] && !m_mask[bus_cpu][1]) begin
                    exp_rd = 32'h0004_0002; m_mask[bus_cpu][1] = 1;
                end
            end else if (bus_addr == 16'h000C)
                exp_rd = {m_pend[bus_cpu][1], 30'd0, m_pend[bus_cpu][0]};
            else if (bus_addr == 16'h0024 || bus_addr == 16'h0028)
                exp_rd = {m_mask[bus_cpu][1], 30'd0, m_mask[bus_cpu][0]};
        end
    end

    // Compare both outputs against the model on every falling edge
    always @(negedge clk) begin
        logic [NC-1:0] exp_irq;
        if (armed && !done) begin
            for (int c = 0; c < NC; c++)
                exp_irq[c] = (m_pend[c][0] && !m_mask[c][0]) ||
                             (m_pend[c][1] && !m_mask[c][1]);
            total++;
            if (bus_rdata !== exp_rd) begin
                bad++;
                $display("FAIL %s rdata actual=%h expected=%h", exp_tag, bus_rdata, exp_rd);
            end
            total++;
            if (ipi_irq !== exp_irq) begin
                bad++;
                $display("FAIL %s ipi_irq actual=%b expected=%b", exp_tag, ipi_irq, exp_irq);
            end
        end
    end

    task automatic acc(input bit w, input int cpu, input int addr,
                       input logic [31:0] data, input string tag);
        @(negedge clk);
        cur_tag = tag;
        bus_wr = w; bus_rd = !w;
        bus_cpu = 2'(cpu); bus_addr = 16'(addr); bus_wdata = data;
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(input int cpu, input int addr, input logic [31:0] d, input string tag);
        acc(1, cpu, addr, d, tag);
    endtask

    task automatic rd(input int cpu, input int addr, input string tag);
        acc(0, cpu, addr, 32'h0, tag);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state seen through event, pending and mask reads
        rd(0, 'h0004, "R1"); rd(2, 'h000C, "R1"); rd(3, 'h0024, "R1");
        // R2: send to CPUs 1 and 3 together
        wr(0, 'h0008, 32'hA, "R2");
        rd(1, 'h000C, "R12"); rd(0, 'h000C, "R12"); rd(3, 'h000C, "R2");
        // R5: write-one unmask, zero write ignored
        wr(1, 'h0028, 32'h1, "R5");
        wr(3, 'h0028, 32'h0, "R5"); rd(3, 'h0028, "R5");
        // R3/R6: event read reports and auto-masks, pending stays
        rd(1, 'h0004, "R3"); rd(1, 'h0024, "R6"); rd(1, 'h000C, "R6");
        rd(1, 'h0004, "R6");
        // R4: acknowledge other
        wr(1, 'h000C, 32'h1, "R4"); rd(1, 'h000C, "R4");
        // R7: window on CPU 2 from CPU 0
        wr(0, 'h1000 + 2*128 + 'h08, 32'h8000_0000, "R7");
        wr(0, 'h1000 + 2*128 + 'h28, 32'h8000_0001, "R7");
        rd(2, 'h0004, "R3");
        wr(1, 'h1000 + 2*128 + 'h0C, 32'h8000_0000, "R7");
        rd(2, 'h000C, "R7");
        wr(3, 'h1000 + 2*128 + 'h24, 32'h8000_0000, "R7"); rd(2, 'h0024, "R7");
        // R9: duplicate send is one occurrence
        wr(0, 'h0008, 32'h8, "R9"); wr(2, 'h0008, 32'h8, "R9");
        wr(3, 'h0028, 32'h1, "R9"); rd(3, 'h0004, "R9");
        wr(3, 'h000C, 32'h1, "R9"); wr(3, 'h0028, 32'h1, "R9");
        rd(3, 'h0004, "R9");
        // R10: masked pending is held and delivered after unmask
        wr(0, 'h0008, 32'h1, "R10"); rd(0, 'h0004, "R10");
        wr(0, 'h0028, 32'h1, "R10"); rd(0, 'h0004, "R10");
        // R11: other before self
        wr(1, 'h1000 + 2*128 + 'h08, 32'h8000_0001, "R11");
        wr(2, 'h0028, 32'h8000_0001, "R11");
        rd(2, 'h0004, "R11"); rd(2, 'h0004, "R11"); rd(2, 'h0004, "R11");
        // R8: hardware event wins and masks nothing
        wr(2, 'h0028, 32'h8000_0001, "R8");
        @(negedge clk); hw_evt_valid[2] = 1'b1; hw_evt_num[32 +: 16] = 16'h0123;
        rd(2, 'h0004, "R8"); rd(2, 'h0028, "R8");
        @(negedge clk); hw_evt_valid[2] = 1'b0;
        rd(2, 'h0004, "R8");
        // R4: acknowledge touches only the accessing CPU
        wr(0, 'h000C, 32'h8000_0000, "R4"); rd(2, 'h000C, "R4");
        // R12: write+read together acts as write; unknown address reads zero
        @(negedge clk); cur_tag = "R12";
        bus_wr = 1; bus_rd = 1; bus_cpu = 2'd1; bus_addr = 16'h0008; bus_wdata = 32'h2;
        @(posedge clk); #1 bus_wr = 0; bus_rd = 0;
        rd(1, 'h0040, "R12"); rd(1, 'h000C, "R12");
        // Random mix over all addresses
        for (int i = 0; i < 600; i++) begin
            int a;
            int sel = $urandom % 12;
            case (sel)
                0: a = 'h0004; 1: a = 'h0008; 2: a = 'h000C; 3: a = 'h0024;
                4: a = 'h0028; 5: a = 'h0040;
                default: a = 'h1000 + ($urandom % NC) * 128 +
                             (sel == 6 ? 'h08 : sel == 7 ? 'h0C : sel == 8 ? 'h24 :
                              sel == 9 ? 'h28 : sel == 10 ? 'h04 : 'h08);
            endcase
            if ($urandom % 8 == 0) begin
                @(negedge clk);
                hw_evt_valid = 4'($urandom);
                hw_evt_num   = {$urandom, $urandom};
            end
            acc($urandom % 2 == 0, $urandom % NC, a,
                ($urandom % 2) ? 32'h8000_0001 : $urandom, "R10");
        end
        repeat (2) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule